// File: doc/BRIEF.md
# Polyphase 9/7 Wavelet Analysis Filter Bank

This block computes one level of the forward 1-D discrete wavelet transform with the biorthogonal 9/7 analysis filter pair. It takes a stream of signed 8-bit samples, one line at a time. For every two input samples it produces one approximation (low-pass) coefficient and one detail (high-pass) coefficient. The two coefficients leave the block together under a single valid strobe.

Internally the stream is split by phase. Even-indexed samples meet the even-position taps of each filter, and odd-indexed samples meet the odd-position taps. Each of the four sub-filters folds its symmetric tap pairs with a pre-adder before the constant multiply. The two phase sums of each band are then added and scaled back by 2^-8.

The line edges are handled by whole-sample mirroring. At the start of a line, tap multiplexers pick mirrored samples from the history register. At the end of a line, a three-step flush pushes mirrored copies of the last samples through that register. The line length is whatever the source marks with the end-of-line flag, as long as it is even and at least 8.

Top module: `dwt97_analysis`

## Requirements
- R1: During reset and after it, `out_valid` stays low until a line has supplied enough samples for its first pair.
- R2: For output n, `out_low` equals floor(S/256), where S = 154·x[2n] + 68·(x[2n−1]+x[2n+1]) − 20·(x[2n−2]+x[2n+2]) − 4·(x[2n−3]+x[2n+3]) + 7·(x[2n−4]+x[2n+4]). Samples and results are two's complement.
- R3: For output n, `out_high` equals floor(T/256), where T = 285·x[2n+1] − 151·(x[2n]+x[2n+2]) − 15·(x[2n−1]+x[2n+3]) + 23·(x[2n−2]+x[2n+4]).
- R4: Before the start of a line, a sample index −k reads x[k]. The first sample is not repeated.
- R5: Past the end of a line of N samples, index N−1+k reads x[N−1−k]. The last sample is not repeated.
- R6: A line of N samples yields exactly N/2 pairs in increasing n. Low and high share one valid cycle, and two pairs never occupy adjacent cycles.
- R7: Pair n < N/2−2 becomes visible in the cycle after the second rising edge that follows acceptance of x[2n+4]. Let E be the edge that accepts the final sample. Pair N/2−2 becomes visible after edge E+3, and pair N/2−1 after edge E+5.
- R8: When `in_valid` is low, `in_sample` and `in_last` are ignored. Idle cycles inside a line do not change any coefficient.
- R9: After the sample flagged by `in_last`, the source keeps `in_valid` low for 3 cycles. The next line may begin in the cycle after that, may have a different even length of at least 8, and is processed without influence from the previous line.
- R10: With 20-bit accumulation, extreme inputs (constant −128, constant 127, alternating 127/−128) give exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| in_last | input | 1 | Marks the final sample of a line, qualified by in_valid |
| out_valid | output | 1 | Output pair strobe |
| out_low | output | OUT_W | Signed approximation coefficient |
| out_high | output | OUT_W | Signed detail coefficient |

## Verification
Single-sample impulses are swept across every position of a 16-sample line. Each coefficient of both filters then appears alone, and a mirroring fault near either edge shows up as a wrong value at a precise output index. Constant and alternating lines at full scale target accumulator width and sign handling, and a short ramp on the minimum line length checks both mirror regions at once. Pseudo-random lines of several lengths are sent with random idle gaps and junk data during the gaps, back to back at the minimum spacing. Every pair is also checked against its predicted arrival cycle, which separates timing faults from arithmetic faults.

// File: rtl/dwt97_pkg.sv
`timescale 1ns/1ps
package dwt97_pkg;
  localparam int COEF_W    = 12;  // signed coefficient width (covers 285)
  localparam int WIN       = 9;   // span of the longer filter
  localparam int FLUSH_LEN = 3;   // mirrored pushes after the last sample
  localparam int FRAC_BITS = 8;   // coefficients are scaled by 2^FRAC_BITS

  // low-pass taps, centre outward
  localparam logic signed [COEF_W-1:0] LO_C0 = 12'sd154;
  localparam logic signed [COEF_W-1:0] LO_C1 = 12'sd68;
  localparam logic signed [COEF_W-1:0] LO_C2 = -12'sd20;
  localparam logic signed [COEF_W-1:0] LO_C3 = -12'sd4;
  localparam logic signed [COEF_W-1:0] LO_C4 = 12'sd7;
  // high-pass taps, centre outward
  localparam logic signed [COEF_W-1:0] HI_C0 = 12'sd285;
  localparam logic signed [COEF_W-1:0] HI_C1 = -12'sd151;
  localparam logic signed [COEF_W-1:0] HI_C2 = -12'sd15;
  localparam logic signed [COEF_W-1:0] HI_C3 = 12'sd23;
endpackage

// File: rtl/dwt97_window.sv
`timescale 1ns/1ps
// Sample history, end-of-line mirror flush and start-of-line mirror muxes.
// win[i] holds x[2n-4+i] for the output n announced by win_valid.
module dwt97_window
  import dwt97_pkg::*;
#(
  parameter int SW       = 8,
  parameter int MAX_LINE = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [SW-1:0]           in_sample,
  input  logic                    in_last,
  output logic                    win_valid,
  output logic [WIN-1:0][SW-1:0]  win
);
  localparam int IDX_W = $clog2(MAX_LINE + FLUSH_LEN) + 1;

  logic [WIN-1:0][SW-1:0] hist;      // hist[0] is the newest sample
  logic [IDX_W-1:0]       nxt_idx;   // index the next push will carry
  logic [IDX_W-1:0]       pos;       // index of hist[0]
  logic [1:0]             fstep;     // 0 idle, 1..FLUSH_LEN mirror push
  logic                   flush_act;
  logic                   push;
  logic [SW-1:0]          push_val;
  logic                   fire;

  assign flush_act = (fstep != 2'd0);
  assign push      = flush_act | in_valid;

  // mirrored sample for flush step m sits at hist[2m-1]
  always_comb begin
    case (fstep)
      2'd1:    push_val = hist[1];
      2'd2:    push_val = hist[3];
      2'd3:    push_val = hist[5];
      default: push_val = in_sample;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) hist <= {hist[WIN-2:0], push_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_idx <= '0;
      pos     <= '0;
      fstep   <= 2'd0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (push) begin
        pos     <= nxt_idx;
        nxt_idx <= nxt_idx + 1'b1;
        fire    <= !nxt_idx[0] && (nxt_idx >= IDX_W'(4));
      end
      if (flush_act) begin
        if (fstep == 2'(FLUSH_LEN)) begin
          fstep   <= 2'd0;
          nxt_idx <= '0;
        end else begin
          fstep <= fstep + 2'd1;
        end
      end else if (in_valid && in_last) begin
        fstep <= 2'd1;
      end
    end
  end

  // start-of-line mirror: a negative index -k reads x[k] from the history
  always_comb begin
    for (int i = 0; i < WIN; i++) win[i] = hist[WIN-1-i];
    if (pos == IDX_W'(4)) begin
      for (int i = 0; i < 4; i++) win[i] = hist[i];
    end
    if (pos == IDX_W'(6)) begin
      win[0] = hist[4];
      win[1] = hist[5];
    end
  end

  assign win_valid = fire;

  // R9: source stays idle while the mirrored tail is pushed
  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    flush_act |-> !in_valid);
  // R6: one output per two pushes, never on neighbouring cycles
  p_fire_apart_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R6: outputs only start once x[4] is held, always on an even index
  p_fire_even_r6: assert property (@(posedge clk) disable iff (rst)
    fire |-> (!pos[0] && pos >= IDX_W'(4)));
endmodule

// File: rtl/dwt97_phase.sv
`timescale 1ns/1ps
// One symmetric polyphase sub-filter: folds tap pairs with a pre-adder,
// multiplies by constant coefficients and registers the sum.
// COEFS slot p weights taps p and K-1-p; for odd K the last slot is the centre.
module dwt97_phase #(
  parameter int SW    = 8,
  parameter int ACC_W = 20,
  parameter int CW    = 12,
  parameter int K     = 4,
  parameter logic [((K+1)/2)*CW-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [K-1:0][SW-1:0]    taps,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] sum
);
  localparam int HALF  = (K + 1) / 2;
  localparam int PAIRS = K / 2;

  logic [ACC_W-1:0] term [HALF];
  logic [ACC_W-1:0] acc;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [SW:0]   pre;
    logic [CW-1:0] c;
    assign c    = COEFS[p*CW +: CW];
    assign pre  = {taps[p][SW-1], taps[p]} + {taps[K-1-p][SW-1], taps[K-1-p]};
    assign term[p] = {{(ACC_W-SW-1){pre[SW]}}, pre} * {{(ACC_W-CW){c[CW-1]}}, c};
  end

  if (K % 2 == 1) begin : g_centre
    logic [CW-1:0] c;
    assign c = COEFS[(HALF-1)*CW +: CW];
    assign term[HALF-1] = {{(ACC_W-SW){taps[PAIRS][SW-1]}}, taps[PAIRS]}
                        * {{(ACC_W-CW){c[CW-1]}}, c};
  end

  always_comb begin
    acc = '0;
    for (int h = 0; h < HALF; h++) acc = acc + term[h];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    sum <= $signed(acc);
  end
endmodule

// File: rtl/dwt97_combine.sv
`timescale 1ns/1ps
// Adds the even and odd phase sums of each band and removes the coefficient scale.
module dwt97_combine #(
  parameter int ACC_W = 20,
  parameter int OUT_W = 12,
  parameter int SHIFT = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [ACC_W-1:0] lo_even,
  input  logic signed [ACC_W-1:0] lo_odd,
  input  logic signed [ACC_W-1:0] hi_even,
  input  logic signed [ACC_W-1:0] hi_odd,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_low,
  output logic [OUT_W-1:0]        out_high
);
  logic signed [ACC_W-1:0] lo_scaled;
  logic signed [ACC_W-1:0] hi_scaled;

  assign lo_scaled = (lo_even + lo_odd) >>> SHIFT;
  assign hi_scaled = (hi_even + hi_odd) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_low  <= lo_scaled[OUT_W-1:0];
    out_high <= hi_scaled[OUT_W-1:0];
  end

  // R10: scaled band sums must fit the output width
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (((&lo_scaled[ACC_W-1:OUT_W-1]) || !(|lo_scaled[ACC_W-1:OUT_W-1])) &&
                  ((&hi_scaled[ACC_W-1:OUT_W-1]) || !(|hi_scaled[ACC_W-1:OUT_W-1]))));
  // R6: output pairs are never back to back
  p_pair_gap_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/dwt97_analysis.sv
`timescale 1ns/1ps
module dwt97_analysis
  import dwt97_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int OUT_W    = 12,
  parameter int ACC_W    = 20,
  parameter int MAX_LINE = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_last,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_low,
  output logic [OUT_W-1:0]    out_high
);
  localparam int SW = SAMPLE_W;

  logic                   win_valid;
  logic [WIN-1:0][SW-1:0] win;

  logic                    v_le, v_lo, v_he, v_ho;
  logic signed [ACC_W-1:0] s_le, s_lo, s_he, s_ho;

  dwt97_window #(.SW(SW), .MAX_LINE(MAX_LINE)) u_window (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sample(in_sample), .in_last(in_last),
    .win_valid(win_valid), .win(win)
  );

  // low band, even samples: x[2n-4], x[2n-2], x[2n], x[2n+2], x[2n+4]
  dwt97_phase #(.SW(SW), .ACC_W(ACC_W), .CW(COEF_W), .K(5),
                .COEFS({LO_C0, LO_C2, LO_C4})) u_lo_even (
    .clk(clk), .rst(rst), .in_valid(win_valid),
    .taps({win[8], win[6], win[4], win[2], win[0]}),
    .out_valid(v_le), .sum(s_le)
  );
  // low band, odd samples: x[2n-3], x[2n-1], x[2n+1], x[2n+3]
  dwt97_phase #(.SW(SW), .ACC_W(ACC_W), .CW(COEF_W), .K(4),
                .COEFS({LO_C1, LO_C3})) u_lo_odd (
    .clk(clk), .rst(rst), .in_valid(win_valid),
    .taps({win[7], win[5], win[3], win[1]}),
    .out_valid(v_lo), .sum(s_lo)
  );
  // high band, even samples: x[2n-2], x[2n], x[2n+2], x[2n+4]
  dwt97_phase #(.SW(SW), .ACC_W(ACC_W), .CW(COEF_W), .K(4),
                .COEFS({HI_C1, HI_C3})) u_hi_even (
    .clk(clk), .rst(rst), .in_valid(win_valid),
    .taps({win[8], win[6], win[4], win[2]}),
    .out_valid(v_he), .sum(s_he)
  );
  // high band, odd samples: x[2n-1], x[2n+1], x[2n+3]
  dwt97_phase #(.SW(SW), .ACC_W(ACC_W), .CW(COEF_W), .K(3),
                .COEFS({HI_C0, HI_C2})) u_hi_odd (
    .clk(clk), .rst(rst), .in_valid(win_valid),
    .taps({win[7], win[5], win[3]}),
    .out_valid(v_ho), .sum(s_ho)
  );

  dwt97_combine #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(FRAC_BITS)) u_combine (
    .clk(clk), .rst(rst),
    .in_valid(v_le & v_lo & v_he & v_ho),
    .lo_even(s_le), .lo_odd(s_lo), .hi_even(s_he), .hi_odd(s_ho),
    .out_valid(out_valid), .out_low(out_low), .out_high(out_high)
  );

  // R1: reset leaves no pair pending
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/dwt97_analysis_test.sv
`timescale 1ns/1ps
module dwt97_analysis_test;
  localparam int SW = 8;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic [OW-1:0] out_low, out_high;

  always #2.5 clk = ~clk;

  dwt97_analysis uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_last(in_last), .out_valid(out_valid), .out_low(out_low), .out_high(out_high)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  int          xs [64];
  int          q_lo[$], q_hi[$], q_cyc[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]);
  endfunction

  function automatic int mir(input int q, input int n);
    if (q < 0) return -q;          // R4
    if (q > n - 1) return 2 * (n - 1) - q;  // R5
    return q;
  endfunction

  function automatic int lo_ref(input int k, input int n);
    int h [5] = '{154, 68, -20, -4, 7};
    int s = 0;
    for (int t = -4; t <= 4; t++) s += h[t < 0 ? -t : t] * xs[mir(2 * k + t, n)];
    return s >>> 8;
  endfunction

  function automatic int hi_ref(input int k, input int n);
    int g [4] = '{285, -151, -15, 23};
    int s = 0;
    for (int t = -3; t <= 3; t++) s += g[t < 0 ? -t : t] * xs[mir(2 * k + 1 + t, n)];
    return s >>> 8;
  endfunction

  function automatic void expect_pair(input int k, input int n, input int at, input string tag);
    q_lo.push_back(lo_ref(k, n));
    q_hi.push_back(hi_ref(k, n));
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endfunction

  // output monitor: compares pairs in order, with their arrival cycle (R7)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_lo.size() == 0) begin
        chk(1'b0, "R6 extra pair", 1, 0);
      end else begin
        int el, eh, ec;
        string tg;
        el = q_lo.pop_front(); eh = q_hi.pop_front();
        ec = q_cyc.pop_front(); tg = q_tag.pop_front();
        chk(int'($signed(out_low)) == el, {tg, " R2 low"}, int'($signed(out_low)), el);
        chk(int'($signed(out_high)) == eh, {tg, " R3 high"}, int'($signed(out_high)), eh);
        chk(cyc == ec, {tg, " R7 cycle"}, cyc, ec);
      end
    end
  end

  // kind: 0 impulse at p, 1 ramp, 2 constant amp, 3 alternating, 4 random
  task automatic send_line(input int n, input int kind, input int p, input int amp,
                           input bit gaps, input string tag);
    for (int j = 0; j < n; j++) begin
      case (kind)
        0: xs[j] = (j == p) ? amp : 0;
        1: xs[j] = j * 13 - 100;
        2: xs[j] = amp;
        3: xs[j] = (j % 2 == 0) ? 127 : -128;
        default: xs[j] = (rnd() % 256) - 128;
      endcase
    end
    for (int j = 0; j < n; j++) begin
      if (gaps) begin
        int idle = rnd() % 3;
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sample = SW'(rnd()); in_last = rnd() % 2 == 1;  // R8
        end
      end
      @(negedge clk);
      in_valid = 1'b1; in_sample = SW'(xs[j]); in_last = (j == n - 1);
      if (j >= 4 && j % 2 == 0 && j <= n - 2) expect_pair((j - 4) / 2, n, cyc + 3, tag);
      if (j == n - 1) begin
        expect_pair(n / 2 - 2, n, cyc + 4, tag);
        expect_pair(n / 2 - 1, n, cyc + 6, tag);
      end
    end
    // R9: exactly three idle cycles, junk on the data lines (R8)
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sample = SW'(rnd()); in_last = 1'b1;
    end
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
    end
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
    end
    // impulses over every position: coefficients and both mirrors
    for (int p = 0; p < 16; p++)
      send_line(16, 0, p, (p % 2 == 0) ? 100 : -77, 1'b0, "R2 R3 R4 R5 impulse");
    // full-scale patterns
    send_line(12, 2, 0, 127, 1'b0, "R10 const max");
    send_line(12, 2, 0, -128, 1'b0, "R10 const min");
    send_line(12, 3, 0, 0, 1'b0, "R10 alternating");
    // shortest line, both mirror regions overlap
    send_line(8, 1, 0, 0, 1'b0, "R4 R5 R9 ramp min length");
    // gapped random lines of varying length, back to back
    send_line(8, 4, 0, 0, 1'b1, "R8 R9 random");
    send_line(10, 4, 0, 0, 1'b1, "R8 R9 random");
    send_line(14, 4, 0, 0, 1'b0, "R6 R9 random");
    send_line(20, 4, 0, 0, 1'b1, "R8 R9 random");
    send_line(32, 4, 0, 0, 1'b1, "R8 R9 random");
    send_line(64, 4, 0, 0, 1'b0, "R6 R9 random");
    send_line(8, 4, 0, 0, 1'b0, "R6 R9 random");
    repeat (20) @(negedge clk);
    chk(q_lo.size() == 0, "R6 missing pairs", q_lo.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule